// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the ordered column addresses for one read or write burst inside an open DRAM row of 256 columns. A controller pulses `start` together with the first column, a burst-length code and a burst-type bit. From the next clock on, the block presents one column address per cycle with a valid flag, and it raises a last flag on the final beat of a fixed-length burst.

Fixed bursts of 2, 4 and 8 beats stay inside an aligned block of that size. In sequential order the low bits count upward and wrap within the block. In interleaved order the low bits of the start column are XORed with a beat counter. A full-page burst walks through the whole row, wraps from the top column back to column 0, and runs until the controller ends it with `term`. A new `start` may arrive on any cycle, including during a burst, and the new sequence begins at once.

Top module: `sdr_colgen`

## Requirements
- R1: While `rst` is high and after it is released, `col_vld` and `col_last` are 0 until the first `start`.
- R2: A `start` sampled on a clock edge makes `col_vld` 1 and `col_addr` equal to the sampled `start_col` after that same edge.
- R3: Burst length code (`bl_sel`) 1, 2 or 3 selects 2, 4 or 8 beats. With `ilv`=0, each beat adds 1 to the low log2(length) bits modulo the length, and the upper column bits keep the start column's value.
- R4: With `ilv`=1 and a fixed length of 2, 4 or 8, beat n carries the start column's low log2(length) bits XOR n, with the upper bits unchanged.
- R5: `col_last` is 1 on exactly the final beat of a fixed-length burst, and `col_vld` returns to 0 on the next cycle unless a new `start` is sampled.
- R6: `bl_sel`=0 gives a single beat: the start column with `col_last` 1 in that same cycle.
- R7: `bl_sel[2]`=1 selects full page. Addresses rise by one per beat and wrap from 255 to 0. `col_last` is never raised, and `ilv` has no effect.
- R8: `term` sampled during a burst without `start` drops `col_vld` on the next cycle. `term` has no effect when no burst is running, and a `start` sampled together with `term` still begins a new burst.
- R9: A `start` sampled during a running burst restarts the sequence at once from the new column, using the newly sampled length and type.
- R10: Length and type are captured only when `start` is sampled. Changes on `bl_sel` or `ilv` during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| bl_sel | input | 3 | Length code: 0/1/2/3 = 1/2/4/8 beats, bit 2 set = full page |
| ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| term | input | 1 | End the running burst early |
| col_addr | output | COL_W | Current column address |
| col_vld | output | 1 | `col_addr` is a beat of a burst |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
All three outputs come from a single register stage. The first address therefore appears one clock after the edge that samples `start`. Each later beat, and the drop of `col_vld` after `term` or after a last beat, also lands exactly one edge after the inputs that cause it. The bench drives inputs on falling edges. It updates a behavioural model on the same rising edge the design uses, and it compares valid, last and, when valid, the address on the next falling edge, so every comparison reads a value that has had half a period to settle. The stimulus covers every length and type over aligned, mid-block and end-of-row start columns, a full-page wrap, early termination, terminate while idle, and restart during a burst.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;
  // burst mode captured when a burst starts
  typedef struct packed {
    logic       full;   // full-page burst, ended only by terminate
    logic       ilv;    // interleaved ordering (fixed lengths only)
    logic [1:0] lg;     // log2 of fixed burst length
  } burst_mode_t;

  function automatic burst_mode_t decode_mode(logic [2:0] code, logic il);
    burst_mode_t m;
    m.full = code[2];
    m.ilv  = il & ~code[2];
    m.lg   = code[1:0];
    return m;
  endfunction
endpackage

// File: rtl/sdr_colgen_seq.sv
module sdr_colgen_seq
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [COL_W-1:0] load_col,
  input  burst_mode_t      load_mode,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] idx_q,
  output burst_mode_t      mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      mode_q <= '0;
    end else if (load) begin
      base_q <= load_col;
      idx_q  <= '0;
      mode_q <= load_mode;
    end else if (adv) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdr_colgen_addr.sv
module sdr_colgen_addr
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] addr,
  output logic             final_beat
);
  localparam int LG_MAX = 3;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] wrap_sum;
  logic [COL_W-1:0] xor_mix;

  // mask of the bits that move inside a fixed burst
  always_comb begin
    mask = '0;
    for (int b = 0; b < LG_MAX; b++)
      if (b < int'(mode.lg)) mask[b] = 1'b1;
    if (mode.full) mask = '1;
  end

  assign wrap_sum = base + idx;
  assign xor_mix  = base ^ idx;

  always_comb begin
    if (mode.ilv) addr = (base & ~mask) | (xor_mix & mask);
    else          addr = (base & ~mask) | (wrap_sum & mask);
  end

  assign final_beat = !mode.full && ((idx & mask) == mask);
endmodule

// File: rtl/sdr_colgen.sv
module sdr_colgen
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_sel,
  input  logic             ilv,
  input  logic             term,
  output logic [COL_W-1:0] col_addr,
  output logic             col_vld,
  output logic             col_last
);
  logic [COL_W-1:0] base_q, idx_q, nxt_addr;
  burst_mode_t      mode_q;
  logic             nxt_final, adv;

  assign adv = col_vld && !col_last && !term && !start;

  sdr_colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst), .load(start), .adv(adv),
    .load_col(start_col), .load_mode(decode_mode(bl_sel, ilv)),
    .base_q(base_q), .idx_q(idx_q), .mode_q(mode_q)
  );

  sdr_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base(base_q), .idx(idx_q + 1'b1), .mode(mode_q),
    .addr(nxt_addr), .final_beat(nxt_final)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_addr <= '0;
      col_vld  <= 1'b0;
      col_last <= 1'b0;
    end else if (start) begin
      col_addr <= start_col;
      col_vld  <= 1'b1;
      col_last <= !bl_sel[2] && (bl_sel[1:0] == 2'd0);
    end else if (adv) begin
      col_addr <= nxt_addr;
      col_last <= nxt_final;
    end else if (col_vld) begin
      col_vld  <= 1'b0;
      col_last <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_colgen_chk.sv
module sdr_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_sel,
  input logic             term,
  input logic [COL_W-1:0] col_addr,
  input logic             col_vld,
  input logic             col_last
);
  logic fp_r;
  always_ff @(posedge clk) begin
    if (rst) fp_r <= 1'b0;
    else if (start) fp_r <= bl_sel[2];
  end

  // R1
  no_last_without_vld_chk: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_vld);
  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_vld && col_addr == $past(start_col)));
  // R5
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (col_vld && col_last && !start) |=> !col_vld);
  // R6
  single_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (start && bl_sel == 3'd0) |=> col_last);
  // R7
  full_page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_r && !start) |=> !col_last);
  // R8
  term_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (col_vld && term && !start) |=> !col_vld);
  // R3
  upper_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (col_vld && !col_last && !start && !term && !fp_r)
      |=> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));
endmodule

bind sdr_colgen sdr_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_col(start_col),
  .bl_sel(bl_sel), .term(term), .col_addr(col_addr),
  .col_vld(col_vld), .col_last(col_last)
);

// File: tb/sdr_colgen_test.sv
module sdr_colgen_test;
  localparam int CLK_PER = 10;

  logic       clk = 0, rst = 1, start = 0, ilv = 0, term = 0;
  logic [7:0] start_col = 0;
  logic [2:0] bl_sel = 0;
  logic [7:0] col_addr;
  logic       col_vld, col_last;

  int checks = 0, fails = 0;
  string scen = "R1";
  bit done = 0;

  sdr_colgen #(.COL_W(8)) uut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .bl_sel(bl_sel), .ilv(ilv), .term(term),
    .col_addr(col_addr), .col_vld(col_vld), .col_last(col_last)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference
  int m_base, m_len, m_idx, m_col;
  bit m_ilv, m_vld, m_last;

  function automatic int ref_addr(int b, int n, int len, bit il);
    int blk, off;
    if (len == 0) return (b + n) % 256;
    blk = (b / len) * len;
    off = b % len;
    if (il) return blk + (off ^ n);
    return blk + ((off + n) % len);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_vld = 0; m_last = 0; m_col = 0;
    end else if (start) begin
      m_base = start_col;
      m_len  = bl_sel[2] ? 0 : (1 << bl_sel[1:0]);
      m_ilv  = ilv && !bl_sel[2];
      m_idx  = 0;
      m_col  = m_base;
      m_vld  = 1;
      m_last = (m_len == 1);
    end else if (m_vld && !term && !m_last) begin
      m_idx++;
      m_col  = ref_addr(m_base, m_idx, m_len, m_ilv);
      m_last = (m_len != 0) && (m_idx == m_len - 1);
    end else begin
      m_vld = 0; m_last = 0;
    end
  end

  function automatic string mode_tag();
    if (m_len == 0) return "R7";
    if (m_len == 1) return "R6";
    return m_ilv ? "R4" : "R3";
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (col_vld !== m_vld) begin
        fails++;
        $display("FAIL %s/R5 col_vld act=%0b exp=%0b t=%0t", scen, col_vld, m_vld, $time);
      end
      checks++;
      if (col_last !== m_last) begin
        fails++;
        $display("FAIL %s/R5 col_last act=%0b exp=%0b t=%0t", scen, col_last, m_last, $time);
      end
      if (m_vld) begin
        checks++;
        if (col_addr !== m_col[7:0]) begin
          fails++;
          $display("FAIL %s/%s col_addr act=%0h exp=%0h t=%0t", scen, mode_tag(), col_addr, m_col, $time);
        end
      end
    end
  end

  task automatic go(input logic [7:0] c, input logic [2:0] b, input logic i);
    @(negedge clk);
    start = 1; start_col = c; bl_sel = b; ilv = i;
    @(negedge clk);
    start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] cols [3] = '{8'h00, 8'h2D, 8'hFE};
    repeat (3) @(negedge clk);
    // R1: outputs idle during and right after reset
    checks++;
    if (col_vld !== 0 || col_last !== 0) begin
      fails++;
      $display("FAIL R1 reset vld/last act=%0b%0b exp=00", col_vld, col_last);
    end
    rst = 0;
    idle(2);
    // R2 R3 R4 R6: every fixed length, both orders, several starts
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 2; i++)
        for (int k = 0; k < 3; k++) begin
          scen = "R2";
          go(cols[k], 3'(b), 1'(i));
          idle((1 << b) + 1);
        end
    // R10: mode inputs change while an 8-beat burst runs
    scen = "R10";
    go(8'h5B, 3'd3, 1'b1);
    bl_sel = 3'd0; ilv = 1'b0;
    idle(10);
    // R8: terminate mid-burst, terminate while idle, start with terminate
    scen = "R8";
    go(8'h45, 3'd3, 1'b0);
    idle(1);
    term = 1; @(negedge clk); term = 0;
    idle(3);
    term = 1; idle(2); term = 0;
    @(negedge clk);
    start = 1; term = 1; start_col = 8'h71; bl_sel = 3'd2; ilv = 1;
    @(negedge clk);
    start = 0; term = 0;
    idle(6);
    // R9: restart during a running burst
    scen = "R9";
    go(8'h10, 3'd3, 1'b0);
    idle(2);
    go(8'hA3, 3'd1, 1'b1);
    idle(4);
    go(8'hC6, 3'd2, 1'b0);
    @(negedge clk);
    go(8'h0F, 3'd0, 1'b0);
    idle(3);
    // R7: full page wraps past 255 and ignores ilv
    scen = "R7";
    go(8'hFA, 3'd4, 1'b0);
    idle(262);
    term = 1; @(negedge clk); term = 0;
    idle(2);
    go(8'h03, 3'd7, 1'b1);
    idle(20);
    term = 1; @(negedge clk); term = 0;
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule